// File: doc/BRIEF.md
# Bicolor Status LED Pattern Generator

This block turns system status into on/off enables for a two-colour indicator. The green channel reports the power state: solid when running, a slow blink while suspended, dark when off. The orange channel reports the battery. A fault or a nearly empty battery gives a fast blink. A low battery gives the slow blink. Charging on AC gives solid orange. In every other case orange is dark.

Each channel has its own pattern timer. The timer advances only on a one-cycle millisecond tick, so the on and off durations are exact multiples of that tick. When the pattern chosen for a channel changes, its timer starts again at the beginning of the on phase. The two channels never affect each other's timing. Durations and battery thresholds are parameters. The defaults give a slow blink of 1000 ms on and 3000 ms off, a fast blink of 1000 ms on and 1000 ms off, a low threshold of 10 % and a critical threshold below 3 %.

Top module: `led_status_gen`

## Requirements
- R1: `pwr_state_i` encodes 0 = off, 1 = on, 2 = suspend; code 3 is treated as off. Green is steadily lit in state 1 and dark in states 0 and 3.
- R2: In state 2, green is lit for SLOW_ON_TICKS ticks and then dark for SLOW_OFF_TICKS ticks, and this repeats.
- R3: When `batt_fault_i` is 1 or `batt_pct_i` < CRIT_PCT, orange is lit for FAST_ON_TICKS ticks and then dark for FAST_OFF_TICKS ticks, repeating, whatever the other inputs are.
- R4: Otherwise, when `batt_pct_i` <= LOW_PCT, orange repeats the slow pattern (SLOW_ON_TICKS lit, SLOW_OFF_TICKS dark).
- R5: Otherwise, when `ac_present_i`=1, `charging_i`=1 and `batt_full_i`=0, orange is steadily lit.
- R6: In every remaining case (battery full, not charging, or AC absent), orange is dark.
- R7: When the pattern selected for a channel changes, that channel shows the first cycle of its on phase on the next clock, independently of the other channel.
- R8: Blink phases advance only on cycles with `tick_i`=1. With no tick, the outputs hold.
- R9: While `rst_ni` is low, both outputs are dark.
- R10: A change of inputs reaches the outputs exactly one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Single-cycle millisecond pulse |
| pwr_state_i | input | 2 | Power state code (0 off, 1 on, 2 suspend) |
| ac_present_i | input | 1 | External power present |
| charging_i | input | 1 | Battery is being charged |
| batt_full_i | input | 1 | Battery full |
| batt_fault_i | input | 1 | Battery abnormal condition |
| batt_pct_i | input | PCT_W | Battery charge level in percent |
| green_o | output | 1 | Green LED enable |
| orange_o | output | 1 | Orange LED enable |

## Verification
The properties assume that the status inputs are held from the reset deassertion onward and change only between clock edges. They also assume `batt_pct_i` stays within 0 to 100. The bench drives every input on the falling edge. It draws percentages from 0 to 100, with extra weight near both thresholds. Input changes are kept rare, so that blink patterns run through several full periods between changes. Ticks arrive at random, so the phases are also tested for holding while no tick is present.

// File: rtl/led_status_pkg.sv
package led_status_pkg;
  typedef enum logic [1:0] {
    PWR_OFF     = 2'd0,
    PWR_ON      = 2'd1,
    PWR_SUSPEND = 2'd2,
    PWR_RSVD    = 2'd3
  } pwr_state_e;

  typedef enum logic [1:0] {
    PAT_DARK  = 2'd0,
    PAT_SOLID = 2'd1,
    PAT_SLOW  = 2'd2,
    PAT_FAST  = 2'd3
  } led_pat_e;
endpackage

// File: rtl/led_green_sel.sv
module led_green_sel
  import led_status_pkg::*;
(
  input  logic [1:0] pwr_state_i,
  output led_pat_e   pat_o
);
  always_comb begin
    unique case (pwr_state_e'(pwr_state_i))
      PWR_ON:      pat_o = PAT_SOLID;
      PWR_SUSPEND: pat_o = PAT_SLOW;
      default:     pat_o = PAT_DARK;
    endcase
  end
endmodule

// File: rtl/led_orange_sel.sv
module led_orange_sel
  import led_status_pkg::*;
#(
  parameter int PCT_W    = 7,
  parameter int LOW_PCT  = 10,
  parameter int CRIT_PCT = 3
) (
  input  logic             ac_present_i,
  input  logic             charging_i,
  input  logic             batt_full_i,
  input  logic             batt_fault_i,
  input  logic [PCT_W-1:0] batt_pct_i,
  output led_pat_e         pat_o
);
  localparam logic [PCT_W-1:0] LowV  = PCT_W'(LOW_PCT);
  localparam logic [PCT_W-1:0] CritV = PCT_W'(CRIT_PCT);

  logic crit, low, chg;
  assign crit = batt_fault_i || (batt_pct_i < CritV);
  assign low  = batt_pct_i <= LowV;
  assign chg  = ac_present_i && charging_i && !batt_full_i;

  // priority: critical > low > charging > dark
  always_comb begin
    if (crit)     pat_o = PAT_FAST;
    else if (low) pat_o = PAT_SLOW;
    else if (chg) pat_o = PAT_SOLID;
    else          pat_o = PAT_DARK;
  end
endmodule

// File: rtl/led_blink_timer.sv
module led_blink_timer
  import led_status_pkg::*;
#(
  parameter int SLOW_ON_TICKS  = 1000,
  parameter int SLOW_OFF_TICKS = 3000,
  parameter int FAST_ON_TICKS  = 1000,
  parameter int FAST_OFF_TICKS = 1000
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  led_pat_e pat_i,
  output logic     led_o
);
  localparam int MaxSlow = (SLOW_ON_TICKS > SLOW_OFF_TICKS) ? SLOW_ON_TICKS : SLOW_OFF_TICKS;
  localparam int MaxFast = (FAST_ON_TICKS > FAST_OFF_TICKS) ? FAST_ON_TICKS : FAST_OFF_TICKS;
  localparam int MaxDur  = (MaxSlow > MaxFast) ? MaxSlow : MaxFast;
  localparam int CntW    = (MaxDur > 1) ? $clog2(MaxDur) : 1;

  led_pat_e        pat_q;
  logic            on_q;
  logic [CntW-1:0] cnt_q;
  logic [CntW-1:0] last;
  logic            blinking;

  assign blinking = (pat_q == PAT_SLOW) || (pat_q == PAT_FAST);

  always_comb begin
    unique case (pat_q)
      PAT_SLOW: last = on_q ? CntW'(SLOW_ON_TICKS - 1) : CntW'(SLOW_OFF_TICKS - 1);
      PAT_FAST: last = on_q ? CntW'(FAST_ON_TICKS - 1) : CntW'(FAST_OFF_TICKS - 1);
      default:  last = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pat_q <= PAT_DARK;
      on_q  <= 1'b1;
      cnt_q <= '0;
    end else if (pat_i != pat_q) begin
      // new pattern: restart in on phase
      pat_q <= pat_i;
      on_q  <= 1'b1;
      cnt_q <= '0;
    end else if (tick_i && blinking) begin
      if (cnt_q == last) begin
        cnt_q <= '0;
        on_q  <= ~on_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign led_o = (pat_q == PAT_SOLID) || (blinking && on_q);
endmodule

// File: rtl/led_status_gen.sv
module led_status_gen
  import led_status_pkg::*;
#(
  parameter int PCT_W          = 7,
  parameter int LOW_PCT        = 10,
  parameter int CRIT_PCT       = 3,
  parameter int SLOW_ON_TICKS  = 1000,
  parameter int SLOW_OFF_TICKS = 3000,
  parameter int FAST_ON_TICKS  = 1000,
  parameter int FAST_OFF_TICKS = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [1:0]       pwr_state_i,
  input  logic             ac_present_i,
  input  logic             charging_i,
  input  logic             batt_full_i,
  input  logic             batt_fault_i,
  input  logic [PCT_W-1:0] batt_pct_i,
  output logic             green_o,
  output logic             orange_o
);
  localparam int NumCh = 2;

  led_pat_e         pat_sel [NumCh];
  logic [NumCh-1:0] led_en;

  led_green_sel u_green_sel (
    .pwr_state_i (pwr_state_i),
    .pat_o       (pat_sel[0])
  );

  led_orange_sel #(
    .PCT_W    (PCT_W),
    .LOW_PCT  (LOW_PCT),
    .CRIT_PCT (CRIT_PCT)
  ) u_orange_sel (
    .ac_present_i (ac_present_i),
    .charging_i   (charging_i),
    .batt_full_i  (batt_full_i),
    .batt_fault_i (batt_fault_i),
    .batt_pct_i   (batt_pct_i),
    .pat_o        (pat_sel[1])
  );

  for (genvar c = 0; c < NumCh; c++) begin : g_ch
    led_blink_timer #(
      .SLOW_ON_TICKS  (SLOW_ON_TICKS),
      .SLOW_OFF_TICKS (SLOW_OFF_TICKS),
      .FAST_ON_TICKS  (FAST_ON_TICKS),
      .FAST_OFF_TICKS (FAST_OFF_TICKS)
    ) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .pat_i  (pat_sel[c]),
      .led_o  (led_en[c])
    );
  end

  assign green_o  = led_en[0];
  assign orange_o = led_en[1];
endmodule

// File: rtl/led_status_chk.sv
module led_status_chk #(
  parameter int PCT_W    = 7,
  parameter int LOW_PCT  = 10,
  parameter int CRIT_PCT = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [1:0]       pwr_state_i,
  input logic             ac_present_i,
  input logic             charging_i,
  input logic             batt_full_i,
  input logic             batt_fault_i,
  input logic [PCT_W-1:0] batt_pct_i,
  input logic             green_o,
  input logic             orange_o
);
  localparam logic [PCT_W-1:0] LowV  = PCT_W'(LOW_PCT);
  localparam logic [PCT_W-1:0] CritV = PCT_W'(CRIT_PCT);

  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  always_comb begin
    if (!rst_ni) p_reset_dark_r9: assert (!green_o && !orange_o);
  end

  p_green_on_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_i == 2'd1) |=> green_o);

  p_green_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_i == 2'd0 || pwr_state_i == 2'd3) |=> !green_o);

  p_suspend_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_i == 2'd2 && $past(pwr_state_i) != 2'd2) |=> green_o);

  p_fault_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(batt_fault_i) && $stable(batt_pct_i) && batt_pct_i >= CritV) |=> orange_o);

  p_charge_solid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ac_present_i && charging_i && !batt_full_i && !batt_fault_i && batt_pct_i > LowV)
      |=> orange_o);

  p_idle_dark_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!ac_present_i || !charging_i || batt_full_i) && !batt_fault_i && batt_pct_i > LowV)
      |=> !orange_o);

  p_hold_no_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !tick_i && $stable(pwr_state_i)) |=> $stable(green_o));
endmodule

bind led_status_gen led_status_chk #(
  .PCT_W    (PCT_W),
  .LOW_PCT  (LOW_PCT),
  .CRIT_PCT (CRIT_PCT)
) u_chk (.*);

// File: tb/tb_led_status_gen.sv
module tb_led_status_gen;
  localparam int SON = 3, SOFF = 9, FON = 4, FOFF = 4;
  localparam int PW = 7, LOW = 10, CRIT = 3;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [1:0] pwr = 2'd1;
  logic ac = 1'b1, chg = 1'b1, full = 1'b0, fault = 1'b0;
  logic [PW-1:0] pct = 7'd50;
  logic g, o;

  always #5 clk = ~clk;

  led_status_gen #(
    .PCT_W(PW), .LOW_PCT(LOW), .CRIT_PCT(CRIT),
    .SLOW_ON_TICKS(SON), .SLOW_OFF_TICKS(SOFF),
    .FAST_ON_TICKS(FON), .FAST_OFF_TICKS(FOFF)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pwr_state_i(pwr),
    .ac_present_i(ac), .charging_i(chg), .batt_full_i(full),
    .batt_fault_i(fault), .batt_pct_i(pct), .green_o(g), .orange_o(o)
  );

  int n_chk = 0, n_err = 0;
  int mg_pat = 0, mg_e = 0, mo_pat = 0, mo_e = 0;
  bit held;

  // pattern codes: 0 dark, 1 solid, 2 slow, 3 fast
  function automatic int exp_g_pat();
    return (pwr == 2'd1) ? 1 : (pwr == 2'd2) ? 2 : 0;
  endfunction

  function automatic int exp_o_pat();
    if (fault || int'(pct) < CRIT) return 3;
    if (int'(pct) <= LOW)          return 2;
    if (ac && chg && !full)        return 1;
    return 0;
  endfunction

  function automatic bit exp_led(int pat, int e);
    case (pat)
      1:       return 1'b1;
      2:       return (e % (SON + SOFF)) < SON;
      3:       return (e % (FON + FOFF)) < FON;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string g_req(int p);
    return (p == 2) ? "R2" : "R1";
  endfunction

  function automatic string o_req(int p);
    case (p)
      3: return "R3";
      2: return "R4";
      1: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(bit act, bit exp, string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int ng, no;
    if (!rst_n) begin
      mg_pat = 0; mg_e = 0; mo_pat = 0; mo_e = 0;
    end else begin
      ng = exp_g_pat();
      no = exp_o_pat();
      if (ng != mg_pat) begin mg_pat = ng; mg_e = 0; end
      else if (tick) mg_e++;
      if (no != mo_pat) begin mo_pat = no; mo_e = 0; end
      else if (tick) mo_e++;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(g, exp_led(mg_pat, mg_e), g_req(mg_pat));
    chk(o, exp_led(mo_pat, mo_e), o_req(mo_pat));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1ed5));
    // R9: reset holds both dark despite active inputs
    @(negedge clk);
    chk(g, 1'b0, "R9");
    chk(o, 1'b0, "R9");
    step(); step();
    chk(g, 1'b0, "R9");
    chk(o, 1'b0, "R9");
    rst_n = 1'b1;
    pwr = 2'd0;
    step(); step();
    // R10: one edge of latency
    pwr = 2'd1;
    #1 chk(g, 1'b0, "R10");
    step();
    chk(g, 1'b1, "R10");
    // R2: two full suspend periods with a tick every cycle
    pwr = 2'd2; tick = 1'b1;
    step();
    chk(g, 1'b1, "R2");
    for (int i = 0; i < 2 * (SON + SOFF); i++) step();
    // R8: no tick, output holds
    for (int i = 0; i < SON + 1; i++) step();
    tick = 1'b0;
    held = g;
    for (int i = 0; i < 20; i++) step();
    chk(g, held, "R8");
    // R7: re-entering suspend restarts in on phase
    tick = 1'b1;
    pwr = 2'd1; step();
    pwr = 2'd2; step();
    chk(g, 1'b1, "R7");
    // orange boundaries
    ac = 1; chg = 1; full = 0; fault = 0; pct = 7'd11;
    step(); chk(o, 1'b1, "R5");
    pct = 7'd10; step(); chk(o, 1'b1, "R4");
    for (int i = 0; i < SON; i++) step();
    chk(o, 1'b0, "R4");
    pct = 7'd3; step(); chk(o, 1'b0, "R4");
    pct = 7'd2; step(); chk(o, 1'b1, "R3");
    pct = 7'd80; fault = 1; step(); step(); chk(o, 1'b1, "R3");
    fault = 0; full = 1; step(); chk(o, 1'b0, "R6");
    full = 0; ac = 0; step(); chk(o, 1'b0, "R6");
    // random phase
    for (int i = 0; i < 20000; i++) begin
      tick = ($urandom_range(0, 1) == 1);
      if ($urandom_range(0, 39) == 0) begin
        case ($urandom_range(0, 5))
          0: pwr   = 2'($urandom_range(0, 3));
          1: ac    = ~ac;
          2: chg   = ~chg;
          3: full  = ~full;
          4: fault = ($urandom_range(0, 3) == 0);
          default: pct = ($urandom_range(0, 1) == 1) ? 7'($urandom_range(0, 100))
                                                     : 7'($urandom_range(0, 13));
        endcase
      end
      step();
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule